// File: doc/BRIEF.md
# Quadrature Bounce-Suppressing Hysteresis Filter

This block sits between a two-phase encoder (mechanical or optical) and a position counter. It samples the two encoder phases, which are asynchronous to the system clock, and turns their Gray-coded motion into a one-clock step pulse with a direction bit. Contact bounce and chatter at a phase edge cannot reach the downstream counter. The filter gets this immunity by adding a deliberate electronic backlash. After a change of direction, one Gray step against the current motion is absorbed silently. A step is accepted only once the shaft has moved two Gray positions the other way. The cost is one position of resolution after every reversal.

Each phase first passes through a synchronizer chain. The synchronized pair is mapped to a position index `{a, a^b}`. A follower register holds the last accepted index. A second register holds the previous sample, which is used to reject samples where both phases changed at once. A four-state machine controls the filter:

- `ST_SETTLE` waits for the synchronizers to fill after reset.
- `SETTLE->NEUTRAL` loads the follower from the live input.
- `ST_NEUTRAL` accepts a first step in either direction: `NEUTRAL->FWD` or `NEUTRAL->REV`.
- `ST_FWD` accepts further forward steps (`FWD->FWD`) and ignores a single step back.
- `ST_REV` behaves the same way in the reverse direction (`REV->REV`).
- A move two positions against the current mode is a reversal (`FWD->REV`, `REV->FWD`), and it emits one event in the new direction.

Top module: `quad_hyst_filter`

## Requirements
- R1: Each phase passes through a SYNC_STAGES-flop synchronizer (default 2). With defaults, a legal phase change applied before clock edge n produces step_pulse high after edge n+2, and not before.
- R2: While rst_n is low, step_pulse and step_dir are 0. After reset the follower loads whatever phase state is then present, so no event occurs at start-up, whatever that state is.
- R3: Position index is {a, a^b}, so forward order of (a,b) is 00, 01, 11, 10, 00. A one-step forward move accepted by the filter gives step_pulse with step_dir = 1.
- R4: A one-step reverse move accepted by the filter gives step_pulse with step_dir = 0.
- R5: step_pulse is high for exactly one clock per accepted step, and only after the sampled index changed. step_dir is valid in that same cycle and holds its value between events.
- R6: Backlash rule. In forward mode, one step backward produces no event. A second consecutive backward step (two positions behind the last accepted index) produces one reverse event and switches to reverse mode. Reverse mode behaves symmetrically.
- R7: Any amount of bouncing across a single phase edge produces exactly one event in total.
- R8: A sample in which both phases changed (index moved by two) produces no event and leaves the follower unchanged.
- R9: Sustained stepping at one Gray step every two clocks yields one event per step, with no missed or extra events.
- R10: The first step after start-up is accepted immediately in either direction, with no backlash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| step_pulse | output | 1 | One-clock pulse per accepted step |
| step_dir | output | 1 | Step direction: 1 forward, 0 reverse |

## Verification
The bench drives the encoder through a series of input patterns, each chosen to separate two kinds of behaviour:

- Plain forward and reverse walks separate correct direction encoding from swapped phases.
- A single step back followed by a second one separates the backlash window from a decoder that counts every change.
- Rapid toggling across one edge shows whether bounce leaks through as extra events.
- A double-phase jump, followed by a path that only yields an event if the follower held its old value, shows whether illegal samples are really discarded.
- A fast uninterrupted run checks for missed steps.
- A reset with a nonzero phase state, followed by a reverse first step, checks start-up behaviour.

// File: rtl/qhf_pkg.sv
package qhf_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_NEUTRAL = 2'd1,
        ST_FWD     = 2'd2,
        ST_REV     = 2'd3
    } qhf_state_e;

    typedef logic [1:0] qhf_idx_t;

    // Gray phase pair to linear position index (forward = +1)
    function automatic qhf_idx_t phase_to_idx(input logic a, input logic b);
        return {a, a ^ b};
    endfunction

endpackage

// File: rtl/qhf_sync.sv
module qhf_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
            end
        end

        assign sync_out[g] = chain[LAST];
    end

endmodule

// File: rtl/qhf_classify.sv
module qhf_classify
    import qhf_pkg::*;
(
    input  qhf_idx_t cur_idx,
    input  qhf_idx_t prev_idx,
    input  qhf_idx_t acc_idx,
    output logic     legal_move,
    output logic     ahead,
    output logic     behind,
    output logic     opposite
);

    qhf_idx_t d_prev;
    qhf_idx_t d_acc;

    always_comb begin
        d_prev     = cur_idx - prev_idx;
        d_acc      = cur_idx - acc_idx;
        legal_move = (d_prev == 2'd1) || (d_prev == 2'd3);
        ahead      = (d_acc == 2'd1);
        behind     = (d_acc == 2'd3);
        opposite   = (d_acc == 2'd2);
    end

endmodule

// File: rtl/qhf_ctrl.sv
module qhf_ctrl
    import qhf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  qhf_idx_t   cur_idx,
    input  logic       legal_move,
    input  logic       ahead,
    input  logic       behind,
    input  logic       opposite,
    output qhf_state_e state,
    output qhf_idx_t   prev_idx,
    output qhf_idx_t   acc_idx,
    output logic       step_pulse,
    output logic       step_dir
);

    localparam int CW = $clog2(SYNC_STAGES + 1);
    localparam logic [CW-1:0] SETTLE_END = CW'(SYNC_STAGES);

    qhf_state_e    state_n;
    logic [CW-1:0] cnt;
    logic          take_fwd;
    logic          take_rev;
    logic          load_now;

    // next-state and event decision
    always_comb begin
        state_n  = state;
        take_fwd = 1'b0;
        take_rev = 1'b0;
        load_now = 1'b0;
        unique case (state)
            ST_SETTLE: begin
                if (cnt == SETTLE_END) begin
                    load_now = 1'b1;
                    state_n  = ST_NEUTRAL;
                end
            end
            ST_NEUTRAL: begin
                if (legal_move && ahead) begin
                    take_fwd = 1'b1;
                    state_n  = ST_FWD;
                end else if (legal_move && behind) begin
                    take_rev = 1'b1;
                    state_n  = ST_REV;
                end
            end
            ST_FWD: begin
                if (legal_move && ahead) begin
                    take_fwd = 1'b1;
                end else if (legal_move && opposite) begin
                    take_rev = 1'b1;
                    state_n  = ST_REV;
                end
            end
            ST_REV: begin
                if (legal_move && behind) begin
                    take_rev = 1'b1;
                end else if (legal_move && opposite) begin
                    take_fwd = 1'b1;
                    state_n  = ST_FWD;
                end
            end
            default: state_n = ST_SETTLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (state == ST_SETTLE && cnt != SETTLE_END) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs and follower registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idx   <= '0;
            acc_idx    <= '0;
            step_pulse <= 1'b0;
            step_dir   <= 1'b0;
        end else begin
            prev_idx   <= cur_idx;
            step_pulse <= take_fwd | take_rev;
            if (load_now || take_fwd || take_rev) begin
                acc_idx <= cur_idx;
            end
            if (take_fwd) begin
                step_dir <= 1'b1;
            end else if (take_rev) begin
                step_dir <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/quad_hyst_filter.sv
module quad_hyst_filter
    import qhf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic step_pulse,
    output logic step_dir
);

    localparam int NPH = 2;

    logic [NPH-1:0] ph_sync;
    qhf_idx_t       cur_idx;
    qhf_idx_t       prev_idx;
    qhf_idx_t       acc_idx;
    qhf_state_e     state;
    logic           legal_move;
    logic           ahead;
    logic           behind;
    logic           opposite;

    qhf_sync #(
        .WIDTH  (NPH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({enc_a, enc_b}),
        .sync_out (ph_sync)
    );

    assign cur_idx = phase_to_idx(ph_sync[1], ph_sync[0]);

    qhf_classify u_classify (
        .cur_idx    (cur_idx),
        .prev_idx   (prev_idx),
        .acc_idx    (acc_idx),
        .legal_move (legal_move),
        .ahead      (ahead),
        .behind     (behind),
        .opposite   (opposite)
    );

    qhf_ctrl #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_idx    (cur_idx),
        .legal_move (legal_move),
        .ahead      (ahead),
        .behind     (behind),
        .opposite   (opposite),
        .state      (state),
        .prev_idx   (prev_idx),
        .acc_idx    (acc_idx),
        .step_pulse (step_pulse),
        .step_dir   (step_dir)
    );

endmodule

// File: rtl/qhf_checker.sv
module qhf_checker
    import qhf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       step_pulse,
    input logic       step_dir,
    input qhf_state_e state,
    input qhf_idx_t   cur_idx,
    input qhf_idx_t   prev_idx,
    input qhf_idx_t   acc_idx
);

    p_settle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> !step_pulse);

    p_pulse_after_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(cur_idx != prev_idx));

    p_dir_matches_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> (step_dir == (state == ST_FWD)));

    p_dir_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |-> $stable(step_dir));

    p_no_illegal_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SETTLE && 2'(cur_idx - prev_idx) == 2'd2) |=> !step_pulse);

    p_backlash_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FWD && 2'(cur_idx - acc_idx) == 2'd3) |=> !step_pulse);

    p_follower_moves_with_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_SETTLE && acc_idx != $past(acc_idx)) |-> step_pulse);

endmodule

bind quad_hyst_filter qhf_checker u_qhf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_pulse (step_pulse),
    .step_dir   (step_dir),
    .state      (state),
    .cur_idx    (cur_idx),
    .prev_idx   (prev_idx),
    .acc_idx    (acc_idx)
);

// File: tb/quad_hyst_filter_bench.sv
module quad_hyst_filter_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0;
    logic enc_b = 1'b0;
    logic step_pulse;
    logic step_dir;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    string cur_req = "R2";

    int    exp_dir_q[$];
    string exp_req_q[$];

    always #10 clk = ~clk;

    quad_hyst_filter u_quad_hyst_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_a      (enc_a),
        .enc_b      (enc_b),
        .step_pulse (step_pulse),
        .step_dir   (step_dir)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // forward order of (a,b): 00,01,11,10 for index 0,1,2,3
    task automatic set_idx(input logic [1:0] idx);
        enc_a = idx[1];
        enc_b = idx[1] ^ idx[0];
    endtask

    // exp: -1 no event, 0 reverse, 1 forward
    task automatic move(input logic [1:0] idx, input int hold, input int exp,
                        input string req);
        @(negedge clk);
        cur_req = req;
        if (exp >= 0) begin
            exp_dir_q.push_back(exp);
            exp_req_q.push_back(req);
        end
        set_idx(idx);
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (6) @(negedge clk);
        check(exp_dir_q.size() == 0, req, "missing events", exp_dir_q.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && step_pulse) begin
            if (exp_dir_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected event", 1, 0);
            end else begin
                int    e;
                string r;
                e = exp_dir_q.pop_front();
                r = exp_req_q.pop_front();
                check(step_dir == e[0], r, "step_dir", int'(step_dir), e);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        bit seen;
        // R2: reset with a nonzero phase state present
        set_idx(2'd2);
        repeat (4) @(negedge clk);
        check(step_pulse == 1'b0, "R2", "pulse in reset", int'(step_pulse), 0);
        check(step_dir == 1'b0, "R2", "dir in reset", int'(step_dir), 0);
        rst_n = 1'b1;
        cur_req = "R2";
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (step_pulse) seen = 1'b1;
        end
        check(!seen, "R2", "start-up event", int'(seen), 0);

        // R1/R5: latency and width of a first forward step (also R10 forward)
        @(negedge clk);
        cur_req = "R1";
        exp_dir_q.push_back(1);
        exp_req_q.push_back("R3");
        set_idx(2'd3);
        @(negedge clk);
        check(step_pulse == 1'b0, "R1", "pulse after 1 edge", int'(step_pulse), 0);
        @(negedge clk);
        check(step_pulse == 1'b0, "R1", "pulse after 2 edges", int'(step_pulse), 0);
        @(negedge clk);
        check(step_pulse == 1'b1, "R1", "pulse after 3 edges", int'(step_pulse), 1);
        @(negedge clk);
        check(step_pulse == 1'b0, "R5", "pulse width", int'(step_pulse), 0);
        check(step_dir == 1'b1, "R5", "dir held", int'(step_dir), 1);
        drain("R3");

        // R3: more forward steps
        move(2'd0, 4, 1, "R3");
        move(2'd1, 4, 1, "R3");
        drain("R3");

        // R6: one step back is absorbed, second reverses
        move(2'd0, 4, -1, "R6");
        repeat (4) @(negedge clk);
        check(exp_dir_q.size() == 0, "R6", "queue after backlash", exp_dir_q.size(), 0);
        move(2'd3, 4, 0, "R6");
        drain("R6");

        // R4: reverse steps
        move(2'd2, 4, 0, "R4");
        move(2'd1, 4, 0, "R4");
        drain("R4");

        // R7: bounce across the 1/0 edge in reverse mode, one event total
        move(2'd0, 1, 0, "R7");
        for (int i = 0; i < 6; i++) begin
            move(2'd1, 1, -1, "R7");
            move(2'd0, 2, -1, "R7");
        end
        drain("R7");

        // R8: illegal jump 0->2 ignored, follower stays at 0
        move(2'd2, 4, -1, "R8");
        move(2'd1, 4, -1, "R8");
        move(2'd0, 4, -1, "R8");
        drain("R8");
        move(2'd3, 4, 0, "R8");
        drain("R8");

        // R9: fast forward run, 2 clocks per step
        move(2'd0, 2, -1, "R9");
        move(2'd1, 2, 1, "R9");
        for (int i = 0; i < 40; i++) begin
            move(2'(i + 2), 2, 1, "R9");
        end
        drain("R9");

        // R10: reset again, first step reverse accepted at once
        @(negedge clk);
        rst_n = 1'b0;
        set_idx(2'd2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check(exp_dir_q.size() == 0, "R2", "queue after reset", exp_dir_q.size(), 0);
        move(2'd1, 4, 0, "R10");
        drain("R10");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule